// File: doc/BRIEF.md
# Isochronous Resource Manager Registers

This block keeps the two shared resource registers that isochronous talkers use to reserve capacity on a serial bus. The first is a 64-bit channel map. Each bit stands for one channel number, and a bit at 1 means that channel is still free. The second is a pool of bandwidth allocation units. The whole bus offers 6,144 units, and one unit is the time taken to send one quadlet at 1,600 Mbps. When asynchronous traffic shares the bus, the isochronous pool starts at 4,915 units.

Requesters reach both registers through one request port. Each request selects a target register and one of four operations:
- read
- write
- compare-and-swap
- claim

On the channel map, claim finds the lowest-numbered free channel and clears its bit in a single atomic step. On the bandwidth pool, claim subtracts the requested amount, but only when that many units remain. A reply comes back one cycle after every request. It carries the prior register value, a success flag and, for a channel claim, the channel number that was won.

Top module: `iso_rsrc_regs`

## Requirements
- R1: After reset, the channel map is all ones, the bandwidth pool holds 4915, and `rsp_valid` is low.
- R2: A read (op code 0) returns the target's current value in `rsp_old` with `rsp_ok`=1 and leaves the target unchanged. For bandwidth, the value is zero-extended. `req_tgt`=0 selects the channel map and `req_tgt`=1 selects the bandwidth pool.
- R3: A write (op code 1) loads `req_data` into the target, returns the prior value and sets `rsp_ok`=1.
- R4: A compare-and-swap (op code 2) whose `req_cmp` equals the current value loads `req_data`, returns the prior value and sets `rsp_ok`=1.
- R5: A compare-and-swap whose `req_cmp` differs from the current value leaves the target unchanged, returns the prior value and sets `rsp_ok`=0.
- R6: A channel claim (op code 3, `req_tgt`=0) clears the lowest-indexed bit that is 1. It returns that bit's index in `rsp_chan`, the prior map in `rsp_old`, and `rsp_ok`=1.
- R7: A channel claim when the map is all zeros sets `rsp_ok`=0 and `rsp_chan`=0 and leaves the map at zero.
- R8: A bandwidth claim (op code 3, `req_tgt`=1) whose amount in `req_data` is at most the remaining units subtracts that amount and sets `rsp_ok`=1. An amount equal to the remaining units leaves 0.
- R9: A bandwidth claim larger than the remaining units sets `rsp_ok`=0 and leaves the pool unchanged.
- R10: A write or compare-and-swap to the bandwidth pool whose new value exceeds 6144 is refused: `rsp_ok`=0 and the pool is unchanged. A new value of exactly 6144 is accepted.
- R11: `rsp_valid` is high in exactly the cycle after each accepted request and low otherwise. `rsp_chan` is 0 for every reply except a successful channel claim.
- R12: `init` reloads both registers to their reset values in the next cycle. A request presented together with `init` is dropped and gets no reply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init | input | 1 | Synchronous reload of both registers |
| req_valid | input | 1 | Request strobe |
| req_op | input | 2 | 0 read, 1 write, 2 compare-and-swap, 3 claim |
| req_tgt | input | 1 | 0 channel map, 1 bandwidth pool |
| req_data | input | 64 | Write value, swap value, or bandwidth amount to claim |
| req_cmp | input | 64 | Expected value for compare-and-swap |
| rsp_valid | output | 1 | Reply strobe, one cycle after the request |
| rsp_ok | output | 1 | Operation succeeded |
| rsp_old | output | 64 | Target value before the operation |
| rsp_chan | output | 6 | Channel index won by a channel claim |

## Verification
The bench covers the following corner cases, each named with the fault it would expose:
- **Claim ordering:** repeated channel claims must walk up from bit 0 and skip holes left by a swap. A design that searched from the top, or cleared the wrong bit, would return the wrong index or leave an extra bit free.
- **Empty channel map:** a claim on an all-zero map must fail. A design without that guard would report success or alter the map.
- **Bandwidth limits:** an exact-fit claim must reach 0, and a claim one unit too large must fail. The bench also writes the pool at 6144 and 6145 to probe the ceiling. An off-by-one comparison would either underflow the pool or refuse a legal value.
- **Request during `init`:** a request presented in the same cycle as `init` must get no reply and must leave both registers at their reset values.

// File: rtl/iso_rsrc_pkg.sv
package iso_rsrc_pkg;

    localparam int unsigned NUM_CH     = 64;
    localparam int unsigned CH_IDX_W   = $clog2(NUM_CH);
    localparam int unsigned BW_W       = 13;
    localparam int unsigned BW_TOTAL   = 6144;
    localparam int unsigned BW_ISO_MAX = 4915;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_CSWAP = 2'd2,
        OP_CLAIM = 2'd3
    } iso_op_e;

    typedef enum logic {
        TGT_CHAN = 1'b0,
        TGT_BW   = 1'b1
    } iso_tgt_e;

    typedef struct packed {
        iso_op_e  op;
        iso_tgt_e tgt;
    } iso_cmd_t;

    function automatic iso_cmd_t decode_cmd(input logic [1:0] op, input logic tgt);
        iso_cmd_t c;
        c.op  = iso_op_e'(op);
        c.tgt = iso_tgt_e'(tgt);
        return c;
    endfunction

endpackage

// File: rtl/iso_chan_reg.sv
module iso_chan_reg
    import iso_rsrc_pkg::*;
#(
    parameter int unsigned N_CH  = NUM_CH,
    parameter int unsigned IDX_W = $clog2(N_CH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             init,
    input  logic             fire,
    input  iso_op_e          op,
    input  logic [N_CH-1:0]  wdata,
    input  logic [N_CH-1:0]  cmp,
    output logic [N_CH-1:0]  cur,
    output logic             ok_c,
    output logic [IDX_W-1:0] idx_c
);

    logic [N_CH-1:0]  map_q;
    logic [N_CH-1:0]  map_nxt;
    logic             any_free;
    logic [IDX_W-1:0] low_idx;
    logic [N_CH-1:0]  clr_mask;

    // lowest-set-bit priority encoder, bit 0 wins
    always_comb begin
        any_free = 1'b0;
        low_idx  = '0;
        for (int i = N_CH - 1; i >= 0; i--) begin
            if (map_q[i]) begin
                any_free = 1'b1;
                low_idx  = IDX_W'(i);
            end
        end
    end

    assign clr_mask = {{(N_CH-1){1'b0}}, 1'b1} << low_idx;

    always_comb begin
        map_nxt = map_q;
        ok_c    = 1'b1;
        idx_c   = '0;
        unique case (op)
            OP_READ:  ok_c = 1'b1;
            OP_WRITE: map_nxt = wdata;
            OP_CSWAP: begin
                if (map_q == cmp) map_nxt = wdata;
                else              ok_c    = 1'b0;
            end
            OP_CLAIM: begin
                if (any_free) begin
                    map_nxt = map_q & ~clr_mask;
                    idx_c   = low_idx;
                end else begin
                    ok_c = 1'b0;
                end
            end
            default: ok_c = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || init)  map_q <= '1;
        else if (fire)    map_q <= map_nxt;
    end

    assign cur = map_q;

    assert_claim_one_bit_R6: assert property (@(posedge clk) disable iff (rst || init)
        (fire && op == OP_CLAIM && any_free) |=>
            ($countones(map_q) == $countones($past(map_q)) - 1));

    assert_claim_empty_stable_R7: assert property (@(posedge clk) disable iff (rst || init)
        (fire && op == OP_CLAIM && map_q == '0) |=> (map_q == '0));

    assert_cswap_miss_stable_R5: assert property (@(posedge clk) disable iff (rst || init)
        (fire && op == OP_CSWAP && map_q != cmp) |=> $stable(map_q));

endmodule

// File: rtl/iso_bw_reg.sv
module iso_bw_reg
    import iso_rsrc_pkg::*;
#(
    parameter int unsigned DATA_W = NUM_CH,
    parameter int unsigned W      = BW_W,
    parameter int unsigned TOTAL  = BW_TOTAL,
    parameter int unsigned INIT_V = BW_ISO_MAX
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              init,
    input  logic              fire,
    input  iso_op_e           op,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] cmp,
    output logic [W-1:0]      cur,
    output logic              ok_c
);

    localparam logic [DATA_W-1:0] TOTAL_X = DATA_W'(TOTAL);
    localparam logic [W-1:0]      INIT_W  = W'(INIT_V);

    logic [W-1:0]      pool_q;
    logic [W-1:0]      pool_nxt;
    logic [DATA_W-1:0] pool_x;
    logic              in_range;
    logic              fits;

    assign pool_x   = {{(DATA_W-W){1'b0}}, pool_q};
    assign in_range = (wdata <= TOTAL_X);
    assign fits     = (wdata <= pool_x);

    always_comb begin
        pool_nxt = pool_q;
        ok_c     = 1'b1;
        unique case (op)
            OP_READ:  ok_c = 1'b1;
            OP_WRITE: begin
                if (in_range) pool_nxt = wdata[W-1:0];
                else          ok_c     = 1'b0;
            end
            OP_CSWAP: begin
                if (cmp == pool_x && in_range) pool_nxt = wdata[W-1:0];
                else                           ok_c     = 1'b0;
            end
            OP_CLAIM: begin
                if (fits) pool_nxt = pool_q - wdata[W-1:0];
                else      ok_c     = 1'b0;
            end
            default: ok_c = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || init) pool_q <= INIT_W;
        else if (fire)   pool_q <= pool_nxt;
    end

    assign cur = pool_q;

    assert_pool_ceiling_R10: assert property (@(posedge clk) disable iff (rst)
        pool_x <= TOTAL_X);

    assert_claim_over_stable_R9: assert property (@(posedge clk) disable iff (rst || init)
        (fire && op == OP_CLAIM && !fits) |=> $stable(pool_q));

    assert_claim_deduct_R8: assert property (@(posedge clk) disable iff (rst || init)
        (fire && op == OP_CLAIM && fits) |=> (pool_q <= $past(pool_q)));

endmodule

// File: rtl/iso_rsrc_regs.sv
module iso_rsrc_regs
    import iso_rsrc_pkg::*;
#(
    parameter int unsigned N_CH  = NUM_CH,
    parameter int unsigned IDX_W = $clog2(N_CH),
    parameter int unsigned BWW   = BW_W,
    parameter int unsigned TOTAL = BW_TOTAL,
    parameter int unsigned BINIT = BW_ISO_MAX
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             init,
    input  logic             req_valid,
    input  logic [1:0]       req_op,
    input  logic             req_tgt,
    input  logic [N_CH-1:0]  req_data,
    input  logic [N_CH-1:0]  req_cmp,
    output logic             rsp_valid,
    output logic             rsp_ok,
    output logic [N_CH-1:0]  rsp_old,
    output logic [IDX_W-1:0] rsp_chan
);

    iso_cmd_t         cmd;
    logic             fire_ch, fire_bw;
    logic [N_CH-1:0]  ch_cur;
    logic             ch_ok;
    logic [IDX_W-1:0] ch_idx;
    logic [BWW-1:0]   bw_cur;
    logic             bw_ok;

    assign cmd     = decode_cmd(req_op, req_tgt);
    assign fire_ch = req_valid && cmd.tgt == TGT_CHAN;
    assign fire_bw = req_valid && cmd.tgt == TGT_BW;

    iso_chan_reg #(.N_CH(N_CH), .IDX_W(IDX_W)) u_chan (
        .clk   (clk),
        .rst   (rst),
        .init  (init),
        .fire  (fire_ch),
        .op    (cmd.op),
        .wdata (req_data),
        .cmp   (req_cmp),
        .cur   (ch_cur),
        .ok_c  (ch_ok),
        .idx_c (ch_idx)
    );

    iso_bw_reg #(.DATA_W(N_CH), .W(BWW), .TOTAL(TOTAL), .INIT_V(BINIT)) u_bw (
        .clk   (clk),
        .rst   (rst),
        .init  (init),
        .fire  (fire_bw),
        .op    (cmd.op),
        .wdata (req_data),
        .cmp   (req_cmp),
        .cur   (bw_cur),
        .ok_c  (bw_ok)
    );

    always_ff @(posedge clk) begin
        if (rst || init) begin
            rsp_valid <= 1'b0;
            rsp_ok    <= 1'b0;
            rsp_old   <= '0;
            rsp_chan  <= '0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                if (cmd.tgt == TGT_CHAN) begin
                    rsp_ok   <= ch_ok;
                    rsp_old  <= ch_cur;
                    rsp_chan <= ch_idx;
                end else begin
                    rsp_ok   <= bw_ok;
                    rsp_old  <= {{(N_CH-BWW){1'b0}}, bw_cur};
                    rsp_chan <= '0;
                end
            end
        end
    end

    assert_reply_follows_R11: assert property (@(posedge clk) disable iff (rst || init)
        req_valid |=> rsp_valid);

    assert_no_stray_reply_R11: assert property (@(posedge clk) disable iff (rst)
        (!req_valid || init) |=> !rsp_valid);

    assert_init_load_R12: assert property (@(posedge clk) disable iff (rst)
        init |=> (ch_cur == '1 && bw_cur == BWW'(BINIT)));

    assert_reset_load_R1: assert property (@(posedge clk)
        rst |=> (ch_cur == '1 && bw_cur == BWW'(BINIT) && !rsp_valid));

endmodule

// File: tb/iso_rsrc_regs_tb.sv
module iso_rsrc_regs_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        init = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'd0;
    logic        req_tgt = 1'b0;
    logic [63:0] req_data = '0;
    logic [63:0] req_cmp = '0;
    logic        rsp_valid;
    logic        rsp_ok;
    logic [63:0] rsp_old;
    logic [5:0]  rsp_chan;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    iso_rsrc_regs u_dut (
        .clk(clk), .rst(rst), .init(init),
        .req_valid(req_valid), .req_op(req_op), .req_tgt(req_tgt),
        .req_data(req_data), .req_cmp(req_cmp),
        .rsp_valid(rsp_valid), .rsp_ok(rsp_ok),
        .rsp_old(rsp_old), .rsp_chan(rsp_chan)
    );

    typedef struct packed {
        logic [1:0]  op;
        logic        tgt;
        logic [63:0] data;
        logic [63:0] cmp;
        logic [63:0] exp_old;
        logic        exp_ok;
        logic [5:0]  exp_chan;
        logic [3:0]  req;
    } vec_t;

    localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;
    localparam int NV = 21;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 1'b0, 64'd0, 64'd0, ONES, 1'b1, 6'd0, 4'd2},                                  // R2 read map
        '{2'd3, 1'b0, 64'd0, 64'd0, ONES, 1'b1, 6'd0, 4'd6},                                  // R6 claim -> ch 0
        '{2'd3, 1'b0, 64'd0, 64'd0, 64'hFFFF_FFFF_FFFF_FFFE, 1'b1, 6'd1, 4'd6},               // R6 claim -> ch 1
        '{2'd2, 1'b0, 64'hFFFF_FFFF_FFFF_FFF0, 64'hFFFF_FFFF_FFFF_FFFC,
                64'hFFFF_FFFF_FFFF_FFFC, 1'b1, 6'd0, 4'd4},                                   // R4 swap hit
        '{2'd2, 1'b0, 64'd0, 64'd0, 64'hFFFF_FFFF_FFFF_FFF0, 1'b0, 6'd0, 4'd5},               // R5 swap miss
        '{2'd3, 1'b0, 64'd0, 64'd0, 64'hFFFF_FFFF_FFFF_FFF0, 1'b1, 6'd4, 4'd6},               // R6 skips holes
        '{2'd1, 1'b0, 64'h8000_0000_0000_0000, 64'd0, 64'hFFFF_FFFF_FFFF_FFE0, 1'b1, 6'd0, 4'd3}, // R3 write
        '{2'd3, 1'b0, 64'd0, 64'd0, 64'h8000_0000_0000_0000, 1'b1, 6'd63, 4'd6},              // R6 top bit
        '{2'd3, 1'b0, 64'd0, 64'd0, 64'd0, 1'b0, 6'd0, 4'd7},                                 // R7 empty claim
        '{2'd0, 1'b0, 64'd0, 64'd0, 64'd0, 1'b1, 6'd0, 4'd7},                                 // R7 map unchanged
        '{2'd0, 1'b1, 64'd0, 64'd0, 64'd4915, 1'b1, 6'd0, 4'd2},                              // R2 read pool
        '{2'd3, 1'b1, 64'd915, 64'd0, 64'd4915, 1'b1, 6'd0, 4'd8},                            // R8 claim 915
        '{2'd3, 1'b1, 64'd4001, 64'd0, 64'd4000, 1'b0, 6'd0, 4'd9},                           // R9 one too many
        '{2'd0, 1'b1, 64'd0, 64'd0, 64'd4000, 1'b1, 6'd0, 4'd9},                              // R9 pool unchanged
        '{2'd3, 1'b1, 64'd4000, 64'd0, 64'd4000, 1'b1, 6'd0, 4'd8},                           // R8 exact fit
        '{2'd1, 1'b1, 64'd6145, 64'd0, 64'd0, 1'b0, 6'd0, 4'd10},                             // R10 above ceiling
        '{2'd1, 1'b1, 64'd6144, 64'd0, 64'd0, 1'b1, 6'd0, 4'd10},                             // R10 at ceiling
        '{2'd2, 1'b1, 64'd7000, 64'd6144, 64'd6144, 1'b0, 6'd0, 4'd10},                       // R10 swap above
        '{2'd2, 1'b1, 64'd100, 64'd6144, 64'd6144, 1'b1, 6'd0, 4'd4},                         // R4 pool swap hit
        '{2'd2, 1'b1, 64'd50, 64'd5, 64'd100, 1'b0, 6'd0, 4'd5},                              // R5 pool swap miss
        '{2'd0, 1'b1, 64'd0, 64'd0, 64'd100, 1'b1, 6'd0, 4'd5}                                // R5 pool unchanged
    };

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // called at a negedge; returns at the next negedge with the reply visible
    task automatic issue(input logic [1:0] op, input logic tgt,
                         input logic [63:0] d, input logic [63:0] c);
        req_valid = 1'b1;
        req_op    = op;
        req_tgt   = tgt;
        req_data  = d;
        req_cmp   = c;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 rsp_valid in reset", {63'd0, rsp_valid}, 64'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R11 idle no reply", {63'd0, rsp_valid}, 64'd0);

        issue(2'd0, 1'b0, 64'd0, 64'd0);
        check("R1 map after reset", rsp_old, ONES);
        issue(2'd0, 1'b1, 64'd0, 64'd0);
        check("R1 pool after reset", rsp_old, 64'd4915);

        for (int i = 0; i < NV; i++) begin
            issue(VECS[i].op, VECS[i].tgt, VECS[i].data, VECS[i].cmp);
            check($sformatf("R%0d vec%0d valid", VECS[i].req, i), {63'd0, rsp_valid}, 64'd1);
            check($sformatf("R%0d vec%0d old", VECS[i].req, i), rsp_old, VECS[i].exp_old);
            check($sformatf("R%0d vec%0d ok", VECS[i].req, i), {63'd0, rsp_ok}, {63'd0, VECS[i].exp_ok});
            check($sformatf("R%0d vec%0d chan", VECS[i].req, i), {58'd0, rsp_chan}, {58'd0, VECS[i].exp_chan});
        end

        // R11: reply strobe drops when no request follows
        @(negedge clk);
        check("R11 strobe clears", {63'd0, rsp_valid}, 64'd0);

        // drain part of the map so init has something to restore
        issue(2'd1, 1'b0, 64'd0, 64'd0);
        // R12: request together with init is dropped
        init = 1'b1;
        issue(2'd3, 1'b0, 64'd0, 64'd0);
        init = 1'b0;
        check("R12 no reply under init", {63'd0, rsp_valid}, 64'd0);
        issue(2'd0, 1'b0, 64'd0, 64'd0);
        check("R12 map reloaded", rsp_old, ONES);
        issue(2'd0, 1'b1, 64'd0, 64'd0);
        check("R12 pool reloaded", rsp_old, 64'd4915);
        issue(2'd3, 1'b0, 64'd0, 64'd0);
        check("R6 claim after init", {58'd0, rsp_chan}, 64'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule